// File: doc/BRIEF.md
# Gated-Clock Charge Accumulator

This block turns the reference-deintegrate window of a dual-slope converter into a running charge total. A free-running divider derives the converter clock from a faster reference clock. The divider produces a one-cycle enable pulse, not a new clock net. Converter clock ticks pass to a counting chain only while the deintegrate gate is high. The gate is brought into the reference clock domain before it is used, so no partial pulses appear.

The gated pulses go through a divide-by-PRESCALE stage and then into a cascaded BCD scaler. With the default ratios, the scaler reading is the accumulated charge. A 200 kHz reference divided by 5 gives the 40 kHz converter clock. An input of i nA keeps the gate open for 40·i ticks in every 400 ms conversion, which is 100·i ticks per second. After division by 100, the scaler advances by i counts per second, so the reading is in nanocoulombs.

A synchronous clear zeroes the charge total and leaves the clock divider running. When the scaler wraps past all nines, it sets a sticky overflow flag.

Top module: `gated_charge_counter`

## Requirements
- R1: `conv_clk_en` is high for exactly one reference cycle in every DIV cycles. Its first pulse is in the DIV-th cycle after reset is released. `clr` does not shift its phase.
- R2: `deint_gate` passes through a two-stage synchroniser. `gated_pulse` is high only in the cycle after a `conv_clk_en` pulse, and only if the gate was high three reference edges earlier. A gate held high for k·DIV consecutive cycles gives exactly k gated pulses. A low gate gives none.
- R3: `scaled_pulse` is high for one cycle, in the cycle after every PRESCALE-th gated pulse counted since reset or the last clear.
- R4: `scaler_bcd` counts scaled pulses in BCD. Decade d sits in bits [4d+3:4d], with the least significant decade at bit 0. Every decade stays in the range 0 to 9. The reading updates in the cycle after a scaled pulse.
- R5: When the scaler steps from all nines, it wraps to zero and sets `overflow`. `overflow` stays set until a clear or a reset.
- R6: `clr` zeroes the prescaler remainder, the scaler and `overflow` at the next edge. It takes priority over a scaled pulse in the same cycle.
- R7: While reset is active, and in the first cycle after it, every output is zero.
- R8: The prescaler remainder is kept while the gate is closed, so gated pulses from separate windows add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the charge total and overflow |
| deint_gate | input | 1 | Deintegrate-phase gate from the converter (asynchronous) |
| conv_clk_en | output | 1 | Converter clock enable, one pulse per DIV cycles |
| gated_pulse | output | 1 | Converter ticks that fall inside the gate |
| scaled_pulse | output | 1 | Gated pulses divided by PRESCALE |
| scaler_bcd | output | 4*DIGITS | BCD charge total |
| overflow | output | 1 | Sticky scaler wrap flag |

## Verification
A wrong divider count shows up within one converter period, as a changed spacing of `conv_clk_en` or of the gated pulses. A wrong prescaler remainder stays hidden until the next PRESCALE boundary, and then the scaler reading is off by one count. For that reason the bench runs gate windows whose lengths are not multiples of PRESCALE, and runs them across clears. A carry error between decades appears only when a decade passes 9, so the bench moves the reading through 12 and then through the full wrap.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  typedef logic [3:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;

  function automatic bcd_t bcd_next(input bcd_t d);
    return (d == BCD_TOP) ? 4'd0 : d + 4'd1;
  endfunction
endpackage

// File: rtl/gcc_ref_divider.sv
module gcc_ref_divider #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
      tick_o <= (cnt == LAST);
    end
  end
endmodule

// File: rtl/gcc_gate_window.sv
module gcc_gate_window #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  input  logic tick_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      pulse_o <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], gate_i};
      pulse_o <= tick_i & sync_q[SYNC_STAGES-1];
    end
  end
endmodule

// File: rtl/gcc_prescaler.sv
module gcc_prescaler #(
  parameter int RATIO = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pulse_i,
  output logic pulse_o
);
  localparam int CW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= pulse_i && (cnt == LAST);
      if (pulse_i) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gcc_bcd_scaler.sv
module gcc_bcd_scaler
  import gcc_pkg::*;
#(
  parameter int DIGITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step_i,
  output logic [4*DIGITS-1:0] bcd_o,
  output logic              ovf_o
);
  logic [DIGITS:0] carry;
  assign carry[0] = step_i;

  for (genvar d = 0; d < DIGITS; d++) begin : g_decade
    bcd_t digit_q;
    assign carry[d+1] = carry[d] && (digit_q == BCD_TOP);
    assign bcd_o[4*d +: 4] = digit_q;

    always_ff @(posedge clk) begin
      if (rst || clr)    digit_q <= '0;
      else if (carry[d]) digit_q <= bcd_next(digit_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          ovf_o <= 1'b0;
    else if (carry[DIGITS])  ovf_o <= 1'b1;
  end
endmodule

// File: rtl/gated_charge_counter.sv
module gated_charge_counter #(
  parameter int DIV      = 5,
  parameter int PRESCALE = 100,
  parameter int DIGITS   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                deint_gate,
  output logic                conv_clk_en,
  output logic                gated_pulse,
  output logic                scaled_pulse,
  output logic [4*DIGITS-1:0] scaler_bcd,
  output logic                overflow
);
  gcc_ref_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .tick_o(conv_clk_en)
  );

  gcc_gate_window #(.SYNC_STAGES(2)) u_gate (
    .clk(clk), .rst(rst), .gate_i(deint_gate),
    .tick_i(conv_clk_en), .pulse_o(gated_pulse)
  );

  gcc_prescaler #(.RATIO(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .clr(clr),
    .pulse_i(gated_pulse), .pulse_o(scaled_pulse)
  );

  gcc_bcd_scaler #(.DIGITS(DIGITS)) u_scaler (
    .clk(clk), .rst(rst), .clr(clr), .step_i(scaled_pulse),
    .bcd_o(scaler_bcd), .ovf_o(overflow)
  );
endmodule

// File: rtl/gcc_checker.sv
module gcc_checker #(
  parameter int DIGITS = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                clr,
  input logic                deint_gate,
  input logic                conv_clk_en,
  input logic                gated_pulse,
  input logic                scaled_pulse,
  input logic [4*DIGITS-1:0] scaler_bcd,
  input logic                overflow
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_clk_en |=> !conv_clk_en); // R1
  AST_GATED_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    gated_pulse |-> $past(conv_clk_en)); // R2
  AST_GATED_NEEDS_GATE: assert property (@(posedge clk) disable iff (rst)
    gated_pulse |-> $past(deint_gate, 3)); // R2
  AST_SCALED_AFTER_GATED: assert property (@(posedge clk) disable iff (rst)
    scaled_pulse |-> $past(gated_pulse)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clr) |=> overflow); // R5
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (scaler_bcd == '0) && !overflow && !scaled_pulse); // R6

  for (genvar d = 0; d < DIGITS; d++) begin : g_chk
    AST_DECADE_RANGE: assert property (@(posedge clk) disable iff (rst)
      scaler_bcd[4*d +: 4] <= 4'd9); // R4
  end
endmodule

bind gated_charge_counter gcc_checker #(.DIGITS(DIGITS)) u_gcc_checker (
  .clk(clk), .rst(rst), .clr(clr), .deint_gate(deint_gate),
  .conv_clk_en(conv_clk_en), .gated_pulse(gated_pulse),
  .scaled_pulse(scaled_pulse), .scaler_bcd(scaler_bcd), .overflow(overflow)
);

// File: tb/gated_charge_counter_test.sv
module gated_charge_counter_test;
  localparam int DIV = 5;
  localparam int PRE = 100;
  localparam int DIG = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic gate = 1'b0;
  logic conv_clk_en, gated_pulse, scaled_pulse, overflow;
  logic [4*DIG-1:0] scaler_bcd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    int          gated;
    int          scaled;
    logic [7:0]  bcd;
    logic        ovf;
  } exp_t;
  exp_t exp_q[$];

  int mon_gated = 0;
  int mon_scaled = 0;
  int exp_gated = 0;
  int exp_scaled = 0;
  int since_clr = 0;
  int reading = 0;
  logic exp_ovf = 1'b0;

  always #2 clk = ~clk;

  gated_charge_counter #(.DIV(DIV), .PRESCALE(PRE), .DIGITS(DIG)) uut (
    .clk(clk), .rst(rst), .clr(clr), .deint_gate(gate),
    .conv_clk_en(conv_clk_en), .gated_pulse(gated_pulse),
    .scaled_pulse(scaled_pulse), .scaler_bcd(scaler_bcd), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: tallies pulses and compares queued expectations
  always @(negedge clk) begin
    if (!rst) begin
      if (gated_pulse)  mon_gated++;
      if (scaled_pulse) mon_scaled++;
    end
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, mon_gated, e.gated, "gated total");
      check(e.req, mon_scaled, e.scaled, "scaled total");
      check(e.req, int'(scaler_bcd), int'(e.bcd), "scaler_bcd");
      check(e.req, int'(overflow), int'(e.ovf), "overflow");
    end
  end

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic expect_now(input string req);
    exp_t e;
    e.req = req; e.gated = exp_gated; e.scaled = exp_scaled;
    e.bcd = to_bcd(reading); e.ovf = exp_ovf;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // driver: open the gate for k converter periods, then settle
  task automatic window(input int k, input string req);
    gate = 1'b1;
    repeat (k * DIV) @(negedge clk);
    gate = 1'b0;
    repeat (12) @(negedge clk);
    for (int i = 0; i < k; i++) begin
      exp_gated++;
      since_clr++;
      if (since_clr % PRE == 0) begin
        exp_scaled++;
        reading++;
        if (reading == 100) begin reading = 0; exp_ovf = 1'b1; end
      end
    end
    expect_now(req);
  endtask

  task automatic do_clear(input string req);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    since_clr = 0; reading = 0; exp_ovf = 1'b0;
    @(negedge clk);
    expect_now(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", int'(conv_clk_en), 0, "tick in reset");
    check("R7", int'(gated_pulse), 0, "gated in reset");
    rst = 1'b0;
    // R1: first tick on the DIV-th cycle, then every DIV cycles
    begin
      int first = -1;
      int n = 0;
      check("R7", int'(scaled_pulse), 0, "scaled after reset");
      for (int c = 1; c <= 30; c++) begin
        @(negedge clk);
        if (conv_clk_en) begin
          n++;
          if (first < 0) first = c;
        end
      end
      check("R1", first, DIV, "first tick cycle");
      check("R1", n, 30 / DIV, "ticks in 30 cycles");
    end
    expect_now("R7");
    // R2: closed gate passes nothing
    repeat (500) @(negedge clk);
    expect_now("R2");
    window(37, "R2");
    // R1: clear does not move the divider phase
    begin
      int gap = 0;
      while (!conv_clk_en) @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      gap = 1;
      while (!conv_clk_en) begin @(negedge clk); gap++; end
      check("R1", gap, DIV, "tick spacing across clear");
      since_clr = 0; reading = 0; exp_ovf = 1'b0;
    end
    window(263, "R3");
    window(37, "R8");
    do_clear("R6");
    window(99, "R8");
    do_clear("R6");
    window(1, "R6");
    window(99, "R3");
    do_clear("R6");
    window(1200, "R4");
    window(8800, "R5");
    window(100, "R5");
    do_clear("R6");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule